// File: doc/BRIEF.md
# Predicated Vector Element Sequencer with Condition-Result Modes

This block walks the elements of one predicated vector operation, from element 0 up to VL-1, one element per clock. For each element whose predicate bit is set it asks an external element ALU for the result. The ALU returns a widened two's-complement result and an overflow flag. The sequencer then builds a 4-bit condition result for that element. A 5-bit mode field sets what happens next: plain writes, clamping to the destination element width, cancelling the result write on a condition-bit test, or stopping the whole vector at the first failing element.

The sequencer emits a result-register write strobe and a condition-field write strobe, each with its address and data. It raises a one-cycle completion pulse and presents the final vector length, which fail-on-first may have shortened. The block has one state machine with three states. IDLE waits for `start`. The transition IDLE→RUN is taken on `start` with a nonzero VL, and the transition IDLE→FINISH is taken on `start` with VL = 0. RUN→FINISH is taken when the last element steps or when fail-on-first stops the vector. FINISH→IDLE always follows after one cycle.

Top module: `vseq_elem_sequencer`

## Requirements
- R1: After reset, the block is in IDLE. `res_we`, `cr_we`, `done` and `alu_req` are 0, and `vl_out` is 0.
- R2: Elements are handled in ascending index order, with at most one write event per element. A masked-out element never requests the ALU. Without zeroing it writes nothing. With zeroing (mode bit 0 = 1 in a mode that does not test a condition bit with rc=1) it writes result 0 and no condition field.
- R3: Mode field layout: bits 4:3 select the kind (00 normal, 01 fail-on-first, 10 saturate, 11 pred-result). Bit 2 is the signed flag in saturate and the invert flag in the testing kinds. Bits 1:0 are the condition-bit selector when rc=1 in a testing kind; otherwise bit 0 is the zeroing flag.
- R4: The condition result is {LT,GT,EQ,SO} at bits 3..0. LT is bit XLEN-1 of the written value, EQ is value==0, GT is neither. Outside saturate, SO equals `alu_ovf`. In normal mode the result is `alu_res[XLEN-1:0]`, and the condition field is written only when rc=1.
- R5: In saturate mode the element width w is XLEN for `elw_in`=00, 8 for 01, 16 for 10 and 32 for 11. An unsigned result is clamped to 0..2^w-1 and zero-extended. A signed result is clamped to -2^(w-1)..2^(w-1)-1 and sign-extended.
- R6: In saturate mode, SO is 1 exactly when clamping happened, whatever `alu_ovf` is.
- R7: In pred-result mode with rc=1, the condition field is written for every active element. The result write happens only if the test passes. A failing element with zeroing writes result 0 instead.
- R8: The test picks condition bit LT/GT/EQ/SO for selector 0/1/2/3 when rc=1, and picks EQ when rc=0. It passes when the bit is 1 with invert=0, or when the bit is 0 with invert=1.
- R9: In fail-on-first mode, the first active element that fails the test writes nothing, and no later element is handled. `vl_out` becomes that element's index, which may be 0. Masked-out elements are not tested.
- R10: With a vector destination, the result address is base+i (modulo 128) and the condition address is 8+i. With a scalar destination, they are base and 0.
- R11: `start` with VL=0 gives `done` in the next cycle, with no ALU request and no write.
- R12: The writes of the last handled element appear together with the one-cycle `done` pulse. `vl_out` equals the VL at `start` in every kind other than fail-on-first.
- R13: `alu_req` with `alu_idx` is held stable until `alu_valid`. One element is consumed per handshake, with no idle cycle between elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| vl_in | input | VLW | Vector length, at most MAXVL |
| mode_in | input | 5 | Mode field (R3) |
| rc_in | input | 1 | Record condition results |
| elw_in | input | 2 | Destination element width code |
| dest_vec_in | input | 1 | Destination is a vector |
| dest_base_in | input | RAW | Destination base register |
| pred_in | input | MAXVL | Resolved predicate mask, bit i for element i |
| alu_req | output | 1 | Element request to ALU |
| alu_idx | output | IDXW | Index of requested element |
| alu_valid | input | 1 | ALU result valid for `alu_idx` |
| alu_res | input | XLEN+2 | Widened signed element result |
| alu_ovf | input | 1 | ALU overflow indication |
| res_we | output | 1 | Result write strobe |
| res_addr | output | RAW | Result register address |
| res_data | output | XLEN | Result data |
| cr_we | output | 1 | Condition field write strobe |
| cr_addr | output | CAW | Condition field address |
| cr_data | output | 4 | Condition field {LT,GT,EQ,SO} |
| done | output | 1 | Completion pulse |
| vl_out | output | VLW | Final vector length |

## Verification
A wrong element index or a stuck RUN state shows up at the ports within one cycle. It appears as a write to an address outside the expected base+i or 8+i sequence, as a write event missing from or added to the reference stream, or as `done` arriving early or late. Wrong kind decoding or a wrong condition-bit selection changes the written data, the condition nibble or a strobe of the very element it affects. A wrong stop rule shows in `vl_out` and in the write stream at the `done` pulse of that operation. Stalling the ALU handshake on a fixed pattern shows whether the index is held or advanced wrongly while a request waits.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        K_NORMAL = 2'b00,
        K_FFIRST = 2'b01,
        K_SAT    = 2'b10,
        K_PRED   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } state_e;

    localparam int CR_VEC_BASE = 8;
    localparam logic [1:0] SEL_EQ = 2'd2;

    function automatic int elw_bits(input logic [1:0] code, input int xlen);
        int w;
        unique case (code)
            2'b01:   w = 8;
            2'b10:   w = 16;
            2'b11:   w = 32;
            default: w = xlen;
        endcase
        if (w > xlen) w = xlen;
        return w;
    endfunction

endpackage

// File: rtl/vseq_clamp.sv
module vseq_clamp #(
    parameter int XLEN = 32
) (
    input  logic signed [XLEN+1:0] val_i,
    input  logic                   sat_en_i,
    input  logic                   signed_i,
    input  logic [1:0]             elw_i,
    output logic [XLEN-1:0]        data_o,
    output logic                   clamped_o
);
    localparam int RW = XLEN + 2;
    localparam logic signed [RW-1:0] ONE = 1;

    logic signed [RW-1:0] hi;
    logic signed [RW-1:0] lo;
    logic signed [RW-1:0] pick;
    int w;

    always_comb begin
        w = vseq_pkg::elw_bits(elw_i, XLEN);
        if (signed_i) begin
            hi = (ONE <<< (w - 1)) - ONE;
            lo = -(ONE <<< (w - 1));
        end else begin
            hi = (ONE <<< w) - ONE;
            lo = '0;
        end
        pick      = val_i;
        clamped_o = 1'b0;
        if (sat_en_i) begin
            if (val_i > hi) begin
                pick      = hi;
                clamped_o = 1'b1;
            end else if (val_i < lo) begin
                pick      = lo;
                clamped_o = 1'b1;
            end
        end
        data_o = pick[XLEN-1:0];
    end

endmodule

// File: rtl/vseq_crtest.sv
module vseq_crtest #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] data_i,
    input  logic            so_i,
    input  logic            rc_i,
    input  logic [1:0]      sel_i,
    input  logic            inv_i,
    output logic [3:0]      cr_o,
    output logic            pass_o
);
    logic lt, gt, eq;
    logic [1:0] which;

    always_comb begin
        lt     = data_i[XLEN-1];
        eq     = (data_i == '0);
        gt     = !lt && !eq;
        cr_o   = {lt, gt, eq, so_i};
        which  = rc_i ? sel_i : vseq_pkg::SEL_EQ;
        pass_o = cr_o[2'd3 - which] ^ inv_i;
    end

endmodule

// File: rtl/vseq_elem_sequencer.sv
module vseq_elem_sequencer #(
    parameter int XLEN  = 32,
    parameter int MAXVL = 32,
    parameter int RAW   = 7,
    parameter int CAW   = 6,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IDXW  = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic [4:0]       mode_in,
    input  logic             rc_in,
    input  logic [1:0]       elw_in,
    input  logic             dest_vec_in,
    input  logic [RAW-1:0]   dest_base_in,
    input  logic [MAXVL-1:0] pred_in,
    output logic             alu_req,
    output logic [IDXW-1:0]  alu_idx,
    input  logic             alu_valid,
    input  logic [XLEN+1:0]  alu_res,
    input  logic             alu_ovf,
    output logic             res_we,
    output logic [RAW-1:0]   res_addr,
    output logic [XLEN-1:0]  res_data,
    output logic             cr_we,
    output logic [CAW-1:0]   cr_addr,
    output logic [3:0]       cr_data,
    output logic             done,
    output logic [VLW-1:0]   vl_out
);
    import vseq_pkg::*;

    state_e             state_q, state_d;
    logic [IDXW-1:0]    idx_q;
    logic [VLW-1:0]     len_q;
    logic [4:0]         mode_q;
    logic               rc_q;
    logic [1:0]         elw_q;
    logic               vec_q;
    logic [RAW-1:0]     base_q;
    logic [MAXVL-1:0]   pred_q;
    logic [VLW-1:0]     vl_q;

    kind_e              kind;
    logic               tests_cr;
    logic               zeroing;
    logic               active;
    logic               last;
    logic               step;
    logic [XLEN-1:0]    sat_data;
    logic               clamped;
    logic               so_bit;
    logic [3:0]         cr_val;
    logic               pass;
    logic               wr_res;
    logic               wr_cr;
    logic               stop_here;
    logic [XLEN-1:0]    res_val;

    // Decode of the latched mode field (kind in bits 4:3)
    always_comb begin
        kind     = kind_e'(mode_q[4:3]);
        tests_cr = (kind == K_FFIRST) || (kind == K_PRED);
        zeroing  = (tests_cr && rc_q) ? 1'b0 : mode_q[0];
        active   = pred_q[idx_q];
        last     = (VLW'(idx_q) + VLW'(1)) == len_q;
        alu_req  = (state_q == ST_RUN) && active;
        alu_idx  = idx_q;
        step     = (state_q == ST_RUN) && (!active || alu_valid);
        so_bit   = (kind == K_SAT) ? clamped : alu_ovf;
    end

    vseq_clamp #(.XLEN(XLEN)) u_clamp (
        .val_i     (alu_res),
        .sat_en_i  (kind == K_SAT),
        .signed_i  (mode_q[2]),
        .elw_i     (elw_q),
        .data_o    (sat_data),
        .clamped_o (clamped)
    );

    vseq_crtest #(.XLEN(XLEN)) u_crtest (
        .data_i (sat_data),
        .so_i   (so_bit),
        .rc_i   (rc_q),
        .sel_i  (mode_q[1:0]),
        .inv_i  (mode_q[2]),
        .cr_o   (cr_val),
        .pass_o (pass)
    );

    // Per-element write decision
    always_comb begin
        wr_res    = 1'b0;
        wr_cr     = 1'b0;
        stop_here = 1'b0;
        res_val   = sat_data;
        if (!active) begin
            wr_res  = zeroing;
            res_val = '0;
        end else begin
            unique case (kind)
                K_FFIRST: begin
                    if (pass) begin
                        wr_res = 1'b1;
                        wr_cr  = rc_q;
                    end else begin
                        stop_here = 1'b1;
                    end
                end
                K_PRED: begin
                    wr_cr   = rc_q;
                    wr_res  = pass || zeroing;
                    res_val = pass ? sat_data : '0;
                end
                default: begin
                    wr_res = 1'b1;
                    wr_cr  = rc_q;
                end
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (vl_in == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (step && (stop_here || last)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            mode_q  <= '0;
            rc_q    <= 1'b0;
            elw_q   <= '0;
            vec_q   <= 1'b0;
            base_q  <= '0;
            pred_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                idx_q  <= '0;
                len_q  <= vl_in;
                mode_q <= mode_in;
                rc_q   <= rc_in;
                elw_q  <= elw_in;
                vec_q  <= dest_vec_in;
                base_q <= dest_base_in;
                pred_q <= pred_in;
            end else if (step && !last && !stop_here) begin
                idx_q <= idx_q + IDXW'(1);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_we   <= 1'b0;
            res_addr <= '0;
            res_data <= '0;
            cr_we    <= 1'b0;
            cr_addr  <= '0;
            cr_data  <= '0;
            vl_q     <= '0;
        end else begin
            res_we <= step && wr_res;
            cr_we  <= step && wr_cr;
            if (step) begin
                res_addr <= vec_q ? (base_q + RAW'(idx_q)) : base_q;
                res_data <= res_val;
                cr_addr  <= vec_q ? (CAW'(CR_VEC_BASE) + CAW'(idx_q)) : '0;
                cr_data  <= cr_val;
            end
            if (state_q == ST_IDLE && start) vl_q <= vl_in;
            else if (step && stop_here)      vl_q <= VLW'(idx_q);
        end
    end

    assign done   = (state_q == ST_FINISH);
    assign vl_out = vl_q;

endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int MAXVL = 32,
    parameter int CAW   = 6,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IDXW  = $clog2(MAXVL)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [VLW-1:0]        vl_in,
    input logic                  alu_req,
    input logic [IDXW-1:0]       alu_idx,
    input logic                  alu_valid,
    input logic                  res_we,
    input logic                  cr_we,
    input logic [CAW-1:0]        cr_addr,
    input logic                  done,
    input logic [VLW-1:0]        vl_out,
    input vseq_pkg::state_e      state_q,
    input logic [IDXW-1:0]       idx_q,
    input logic [VLW-1:0]        len_q,
    input logic [4:0]            mode_q,
    input logic                  vec_q
);
    import vseq_pkg::*;

    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: a waiting request keeps its index
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req && !alu_valid) |=> (alu_req && $stable(alu_idx)));

    // R2: an accepted element moves the index forward by exactly one, or ends the run
    a_r2_index_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req && alu_valid) |=> ((state_q != ST_RUN) || (idx_q == $past(idx_q) + IDXW'(1))));

    // R10: vector condition results start at field 8
    a_r10_cr_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && vec_q) |-> (cr_addr >= CAW'(CR_VEC_BASE)));

    // R11: empty vector completes at once without traffic
    a_r11_empty_op: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && vl_in == '0) |=> (done && !alu_req && !res_we && !cr_we));

    // R9: the reported length never exceeds the requested one
    a_r9_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= len_q));

    // R12: kinds other than fail-on-first keep the length
    a_r12_vl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q[4:3] != 2'b01) |-> (vl_out == len_q));

endmodule

bind vseq_elem_sequencer vseq_checker #(
    .MAXVL (MAXVL),
    .CAW   (CAW),
    .VLW   (VLW),
    .IDXW  (IDXW)
) u_vseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl_in     (vl_in),
    .alu_req   (alu_req),
    .alu_idx   (alu_idx),
    .alu_valid (alu_valid),
    .res_we    (res_we),
    .cr_we     (cr_we),
    .cr_addr   (cr_addr),
    .done      (done),
    .vl_out    (vl_out),
    .state_q   (state_q),
    .idx_q     (idx_q),
    .len_q     (len_q),
    .mode_q    (mode_q),
    .vec_q     (vec_q)
);

// File: tb/tb_vseq_elem_sequencer.sv
`timescale 1ns/1ps
module tb_vseq_elem_sequencer;
    localparam int XLEN  = 32;
    localparam int MAXVL = 32;
    localparam int RAW   = 7;
    localparam int CAW   = 6;
    localparam int VLW   = $clog2(MAXVL + 1);
    localparam int IDXW  = $clog2(MAXVL);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLW-1:0]   vl_in = '0;
    logic [4:0]       mode_in = '0;
    logic             rc_in = 1'b0;
    logic [1:0]       elw_in = '0;
    logic             dest_vec_in = 1'b0;
    logic [RAW-1:0]   dest_base_in = '0;
    logic [MAXVL-1:0] pred_in = '0;
    logic             alu_req;
    logic [IDXW-1:0]  alu_idx;
    logic             alu_valid = 1'b0;
    logic [XLEN+1:0]  alu_res = '0;
    logic             alu_ovf = 1'b0;
    logic             res_we;
    logic [RAW-1:0]   res_addr;
    logic [XLEN-1:0]  res_data;
    logic             cr_we;
    logic [CAW-1:0]   cr_addr;
    logic [3:0]       cr_data;
    logic             done;
    logic [VLW-1:0]   vl_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    longint res_tab [MAXVL];
    logic   ovf_tab [MAXVL];

    logic            ev_rwe   [MAXVL];
    logic [RAW-1:0]  ev_raddr [MAXVL];
    logic [XLEN-1:0] ev_rdata [MAXVL];
    logic            ev_cwe   [MAXVL];
    logic [CAW-1:0]  ev_caddr [MAXVL];
    logic [3:0]      ev_cdata [MAXVL];

    always #2.5 clk = ~clk;

    vseq_elem_sequencer #(.XLEN(XLEN), .MAXVL(MAXVL), .RAW(RAW), .CAW(CAW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .mode_in(mode_in),
        .rc_in(rc_in), .elw_in(elw_in), .dest_vec_in(dest_vec_in),
        .dest_base_in(dest_base_in), .pred_in(pred_in), .alu_req(alu_req),
        .alu_idx(alu_idx), .alu_valid(alu_valid), .alu_res(alu_res), .alu_ovf(alu_ovf),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data), .cr_we(cr_we),
        .cr_addr(cr_addr), .cr_data(cr_data), .done(done), .vl_out(vl_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic clear_tab();
        for (int i = 0; i < MAXVL; i++) begin
            res_tab[i] = 0;
            ovf_tab[i] = 1'b0;
        end
    endtask

    task automatic check1(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input int vl, input logic [4:0] mode,
                          input logic rc, input logic [1:0] elw, input logic vec,
                          input logic [RAW-1:0] base, input logic [MAXVL-1:0] pred,
                          input logic stall);
        int nev = 0;
        int exp_vl = vl;
        int exp_hs = 0;
        int ptr = 0;
        int hs = 0;
        int w;
        logic kind_test;
        logic zeroing;
        logic finished = 1'b0;
        // reference model
        kind_test = (mode[4:3] == 2'b01) || (mode[4:3] == 2'b11);
        zeroing = (kind_test && rc) ? 1'b0 : mode[0];
        w = (elw == 2'b01) ? 8 : (elw == 2'b10) ? 16 : (elw == 2'b11) ? 32 : XLEN;
        for (int i = 0; i < vl; i++) begin
            longint v;
            longint hi;
            longint lo;
            logic so;
            logic [XLEN-1:0] d;
            logic [3:0] cr;
            int sel;
            logic pass;
            logic rw;
            logic cw;
            if (!pred[i]) begin
                if (zeroing) begin
                    ev_rwe[nev] = 1'b1; ev_raddr[nev] = vec ? RAW'(base + RAW'(i)) : base;
                    ev_rdata[nev] = '0; ev_cwe[nev] = 1'b0; ev_caddr[nev] = '0; ev_cdata[nev] = '0;
                    nev++;
                end
                continue;
            end
            exp_hs++;
            v = res_tab[i];
            so = ovf_tab[i];
            if (mode[4:3] == 2'b10) begin
                if (mode[2]) begin
                    hi = (longint'(1) << (w - 1)) - 1;
                    lo = -(longint'(1) << (w - 1));
                end else begin
                    hi = (longint'(1) << w) - 1;
                    lo = 0;
                end
                so = 1'b0;
                if (v > hi) begin v = hi; so = 1'b1; end
                else if (v < lo) begin v = lo; so = 1'b1; end
            end
            d = v[XLEN-1:0];
            cr = {d[XLEN-1], !d[XLEN-1] && (d != 0), d == 0, so};
            sel = rc ? int'(mode[1:0]) : 2;
            pass = (cr[3 - sel] != mode[2]);
            rw = 1'b1;
            cw = rc;
            if (mode[4:3] == 2'b01 && !pass) begin
                exp_vl = i;
                break;
            end
            if (mode[4:3] == 2'b11) begin
                rw = pass || zeroing;
                if (!pass) d = '0;
            end
            if (rw || cw) begin
                ev_rwe[nev] = rw; ev_raddr[nev] = vec ? RAW'(base + RAW'(i)) : base;
                ev_rdata[nev] = d; ev_cwe[nev] = cw;
                ev_caddr[nev] = vec ? CAW'(8 + i) : '0; ev_cdata[nev] = cr;
                nev++;
            end
        end
        // drive
        @(negedge clk);
        vl_in = VLW'(vl); mode_in = mode; rc_in = rc; elw_in = elw;
        dest_vec_in = vec; dest_base_in = base; pred_in = pred; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (res_we || cr_we) begin
                checks++;
                if (ptr >= nev) begin
                    failures++;
                    $display("FAIL %s extra write: got res_we=%0d cr_we=%0d expected none", tag, res_we, cr_we);
                end else if (res_we !== ev_rwe[ptr] || cr_we !== ev_cwe[ptr] ||
                             (res_we && (res_addr !== ev_raddr[ptr] || res_data !== ev_rdata[ptr])) ||
                             (cr_we && (cr_addr !== ev_caddr[ptr] || cr_data !== ev_cdata[ptr]))) begin
                    failures++;
                    $display("FAIL %s write %0d: got we=%0d/%0d raddr=%0d rdata=%h caddr=%0d cr=%b expected we=%0d/%0d raddr=%0d rdata=%h caddr=%0d cr=%b",
                             tag, ptr, res_we, cr_we, res_addr, res_data, cr_addr, cr_data,
                             ev_rwe[ptr], ev_cwe[ptr], ev_raddr[ptr], ev_rdata[ptr], ev_caddr[ptr], ev_cdata[ptr]);
                end
                ptr++;
            end
            if (done) begin
                finished = 1'b1;
                break;
            end
            if (alu_req) begin
                alu_valid = !(stall && (c % 3 == 1));
                alu_res = res_tab[alu_idx][XLEN+1:0];
                alu_ovf = ovf_tab[alu_idx];
                if (alu_valid) hs++;
            end else begin
                alu_valid = 1'b0;
            end
            @(negedge clk);
        end
        alu_valid = 1'b0;
        check1(tag, "done reached", longint'(finished), 1);
        check1(tag, "vl_out (R12 kept / R9 truncated)", longint'(vl_out), exp_vl);
        check1(tag, "write events", ptr, nev);
        check1("R13", "ALU handshakes", hs, exp_hs);
        @(negedge clk);
        check1("R12", "done single pulse", longint'(done), 0);
    endtask

    initial begin
        clear_tab();
        repeat (3) @(negedge clk);
        // R1 reset state
        check1("R1", "res_we", longint'(res_we), 0);
        check1("R1", "cr_we", longint'(cr_we), 0);
        check1("R1", "done", longint'(done), 0);
        check1("R1", "alu_req", longint'(alu_req), 0);
        check1("R1", "vl_out", longint'(vl_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 normal mode, rc=1, vector dest, stalled ALU
        clear_tab();
        res_tab[0] = 12; res_tab[1] = -7; res_tab[2] = 0; res_tab[3] = 64'h7fff_ffff; res_tab[4] = 3;
        ovf_tab[1] = 1'b1;
        run_op("R4", 5, 5'b00000, 1'b1, 2'b00, 1'b1, 7'd10, 32'h1f, 1'b1);

        // R2 masked skip, no zeroing
        clear_tab();
        for (int i = 0; i < 6; i++) res_tab[i] = 100 + i;
        run_op("R2", 6, 5'b00000, 1'b0, 2'b00, 1'b1, 7'd20, 32'b010110, 1'b0);
        // R2 masked zeroing
        run_op("R2", 6, 5'b00001, 1'b1, 2'b00, 1'b1, 7'd20, 32'b010110, 1'b1);

        // R10 scalar destination
        run_op("R10", 3, 5'b00000, 1'b1, 2'b00, 1'b0, 7'd5, 32'h7, 1'b0);

        // R5/R6 unsigned saturate at 8 bits, overflow input ignored
        clear_tab();
        res_tab[0] = 300; res_tab[1] = -5; res_tab[2] = 100; res_tab[3] = 255; res_tab[4] = 256;
        ovf_tab[2] = 1'b1;
        run_op("R5", 5, 5'b10000, 1'b1, 2'b01, 1'b1, 7'd0, 32'h1f, 1'b1);
        // R5/R6 signed saturate at 16 bits
        clear_tab();
        res_tab[0] = 40000; res_tab[1] = -40000; res_tab[2] = -32768; res_tab[3] = 32767; res_tab[4] = -5;
        run_op("R6", 5, 5'b10100, 1'b1, 2'b10, 1'b1, 7'd40, 32'h1f, 1'b0);
        // R5 signed saturate at full width
        clear_tab();
        res_tab[0] = 64'sd2147483648; res_tab[1] = -64'sd2147483649; res_tab[2] = 17;
        run_op("R5", 3, 5'b10100, 1'b1, 2'b00, 1'b1, 7'd60, 32'h7, 1'b0);
        // R5 unsigned saturate at full width
        res_tab[0] = 64'sd4294967296; res_tab[1] = -1; res_tab[2] = 64'sd4294967295;
        run_op("R5", 3, 5'b10000, 1'b0, 2'b00, 1'b1, 7'd60, 32'h7, 1'b0);

        // R7 pred-result rc=1, test GT
        clear_tab();
        res_tab[0] = 5; res_tab[1] = -3; res_tab[2] = 0; res_tab[3] = 7;
        run_op("R7", 4, 5'b11001, 1'b1, 2'b00, 1'b1, 7'd30, 32'hf, 1'b1);
        // R7/R8 pred-result rc=0 with zeroing, test EQ
        clear_tab();
        res_tab[0] = 0; res_tab[1] = 4; res_tab[2] = 0; res_tab[3] = -1;
        run_op("R8", 4, 5'b11001, 1'b0, 2'b00, 1'b1, 7'd30, 32'hf, 1'b0);
        // R8 pred-result inverted SO test
        clear_tab();
        res_tab[0] = 1; res_tab[1] = 2; res_tab[2] = 3;
        ovf_tab[1] = 1'b1;
        run_op("R8", 3, 5'b11111, 1'b1, 2'b00, 1'b1, 7'd30, 32'h7, 1'b0);

        // R9 fail-on-first stops at element 2
        clear_tab();
        res_tab[0] = -1; res_tab[1] = -2; res_tab[2] = 3; res_tab[3] = -4;
        run_op("R9", 4, 5'b01000, 1'b1, 2'b00, 1'b1, 7'd50, 32'hf, 1'b1);
        // R9 fail at element 0
        clear_tab();
        res_tab[0] = 5; res_tab[1] = -2;
        run_op("R9", 2, 5'b01000, 1'b1, 2'b00, 1'b1, 7'd50, 32'h3, 1'b0);
        // R9 masked element not tested
        clear_tab();
        res_tab[0] = -1; res_tab[1] = -2; res_tab[2] = 9; res_tab[3] = -3;
        run_op("R9", 4, 5'b01000, 1'b1, 2'b00, 1'b1, 7'd50, 32'b1011, 1'b1);
        // R9 inverted test, all pass
        clear_tab();
        res_tab[0] = 1; res_tab[1] = 0; res_tab[2] = 3;
        run_op("R9", 3, 5'b01100, 1'b1, 2'b00, 1'b1, 7'd50, 32'h7, 1'b0);

        // R11 empty vector
        run_op("R11", 0, 5'b00000, 1'b1, 2'b00, 1'b1, 7'd1, 32'hffff_ffff, 1'b0);

        // R12/R13 full length, base wraps
        clear_tab();
        for (int i = 0; i < MAXVL; i++) res_tab[i] = i * 3 - 10;
        run_op("R12", MAXVL, 5'b00000, 1'b1, 2'b00, 1'b1, 7'd100, 32'hffff_ffff, 1'b0);
        run_op("R3", MAXVL, 5'b11010, 1'b1, 2'b00, 1'b1, 7'd100, 32'hf0f0_f0f0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule